// File: doc/BRIEF.md
# ADC Power-Up Configuration Sequencer

This block brings a multi-channel high-speed analog-to-digital converter from its power-on state to a running single-channel, 8-bit output configuration. After a single start request it works through a fixed program held in a small step ROM. Pin steps set the converter's active-low reset and active-high power-down lines. SPI steps send one write frame each over a write-only serial link. A final wait step covers the converter's restart time. Every step except the wait takes exactly one microcode tick.

Some converter mode settings, namely the channel/mode register and the output-width field, only take effect after a power-down cycle. For that reason the program pulses power-down again once all writes are done. It then waits at least the startup time before it reports completion. Parameters decide whether the jitter-reduction write is included and how many LVDS drive-strength escalation writes are appended.

Top module: `adc_cfg_seq`

## Requirements
- R1: While the system reset is held, the outputs are: converter reset 1 (released), power-down 0, CS_N 1, SCLK 0, MOSI 0, busy 0, done 0.
- R2: A start seen while idle raises busy on the next cycle. Busy then stays high for exactly (IDX_WAIT + WAIT_TICKS) × TICK_CYCLES cycles. Done is high for exactly one cycle, in the first cycle busy is low.
- R3: Each pin or SPI step lasts exactly TICK_CYCLES (default 1024) system clocks. The pin change or frame start of step k comes 1 + k × TICK_CYCLES cycles after busy rises.
- R4: The first four steps are, in order: converter reset driven 0; reset driven 1; power-down driven 1; power-down driven 0.
- R5: Each SPI frame has 24 bits: an 8-bit register address, then 16 data bits, most significant bit first. CS_N stays low for the whole frame. SCLK idles low and its rising edge samples MOSI. MOSI changes only on a falling SCLK edge or when CS_N falls.
- R6: SCLK high and low phases each last CLK_DIV/2 system clocks (5 by default, giving a 10 MHz SCLK from 100 MHz).
- R7: The first five frames are, in order: 0x31←0x0001, 0x3A←0x0202, 0x3B←0x0202, 0x53←LVDS_MODE (default 0x0001), 0x56←0x0008.
- R8: With JITTER_EN set, the next frame is 0x30←0x00FF. With JITTER_EN clear, that frame is not sent.
- R9: DRIVE_WRITES = n (0 to 4) appends n frames to register 0x11. Their data is the first n of 0x0777, 0x0666, 0x0555, 0x0444, in that order.
- R10: After the last frame, power-down is driven 1 for one tick and then 0. No frame is sent after this second power-down cycle begins.
- R11: Done is not raised earlier than STARTUP_CYCLES (default 2000 = 20 µs) clocks after the final power-down release.
- R12: A start request while busy has no effect: no extra frame, and no change to the step timing or to the busy length.
- R13: A frame is only sent while converter reset is 1 and power-down is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock (100 MHz) |
| rst_ni | input | 1 | Asynchronous active-low system reset |
| start_i | input | 1 | Start request, sampled on the clock edge |
| busy_o | output | 1 | High while the program is running |
| done_o | output | 1 | One-cycle completion pulse |
| adc_rst_n_o | output | 1 | Converter reset, active low |
| adc_pd_o | output | 1 | Converter power-down, active high |
| spi_sclk_o | output | 1 | SPI serial clock |
| spi_mosi_o | output | 1 | SPI serial data to the converter |
| spi_cs_n_o | output | 1 | SPI chip select, active low |

## Verification
Every result is due at a fixed cycle counted from the edge that samples start. Busy rises after that edge (t0). The pin change or CS_N fall of step k appears after edge t0 + 1 + k × 1024, because the step register and the pin or frame register each add one cycle. Busy falls and done rises after edge t0 + 18 × 1024 in the full configuration. The bench timestamps each output transition on the falling clock edge and compares the stamps with these formulas. It also checks SCLK phase widths and MOSI stability inside each frame, cycle by cycle.

// File: rtl/adc_cfg_pkg.sv
package adc_cfg_pkg;

    localparam int ADDR_W     = 8;
    localparam int DATA_W     = 16;
    localparam int FRAME_BITS = ADDR_W + DATA_W;

    typedef enum logic [1:0] {
        STEP_PIN  = 2'd0,
        STEP_SPI  = 2'd1,
        STEP_WAIT = 2'd2
    } step_kind_t;

    typedef struct packed {
        step_kind_t        kind;
        logic              rst_n;
        logic              pd;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } step_t;

    function automatic step_t pin_step(input logic r, input logic p);
        step_t s;
        s.kind  = STEP_PIN;
        s.rst_n = r;
        s.pd    = p;
        s.addr  = '0;
        s.data  = '0;
        return s;
    endfunction

    function automatic step_t spi_step(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        step_t s;
        s.kind  = STEP_SPI;
        s.rst_n = 1'b1;
        s.pd    = 1'b0;
        s.addr  = a;
        s.data  = d;
        return s;
    endfunction

endpackage

// File: rtl/adc_cfg_tick.sv
module adc_cfg_tick #(
    parameter int TICK_CYCLES = 1024
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    output logic tick_end_o
);
    localparam int CNT_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i) begin
            cnt_d = '0;
        end else if (cnt_q == LAST) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    // Terminal count is LAST, which the counter can reach.
    assign tick_end_o = run_i && (cnt_q == LAST);

    assert_wrap_to_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(tick_end_o) |-> (cnt_q == '0));

endmodule

// File: rtl/adc_cfg_spi.sv
module adc_cfg_spi
    import adc_cfg_pkg::*;
#(
    parameter int CLK_DIV = 10
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  go_i,
    input  logic [FRAME_BITS-1:0] frame_i,
    output logic                  sclk_o,
    output logic                  mosi_o,
    output logic                  cs_n_o
);
    localparam int HALF  = (CLK_DIV >= 2) ? CLK_DIV / 2 : 1;
    localparam int DIV_W = (HALF > 1) ? $clog2(HALF) : 1;
    localparam int BIT_W = $clog2(FRAME_BITS);
    localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF - 1);
    localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  active;
        logic                  cs_n;
        logic                  sclk;
        logic [DIV_W-1:0]      div;
        logic [BIT_W-1:0]      bitn;
        logic [FRAME_BITS-1:0] shreg;
    } spi_state_t;

    spi_state_t d, q;

    always_comb begin
        d = q;
        if (!q.active) begin
            if (go_i) begin
                d.active = 1'b1;
                d.cs_n   = 1'b0;
                d.sclk   = 1'b0;
                d.div    = '0;
                d.bitn   = '0;
                d.shreg  = frame_i;
            end
        end else if (q.div == DIV_LAST) begin
            d.div = '0;
            if (!q.sclk) begin
                d.sclk = 1'b1;
            end else begin
                d.sclk = 1'b0;
                if (q.bitn == BIT_LAST) begin
                    d.active = 1'b0;
                    d.cs_n   = 1'b1;
                end else begin
                    d.bitn  = q.bitn + 1'b1;
                    d.shreg = {q.shreg[FRAME_BITS-2:0], 1'b0};
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.active <= 1'b0;
            q.cs_n   <= 1'b1;
            q.sclk   <= 1'b0;
            q.div    <= '0;
            q.bitn   <= '0;
            q.shreg  <= '0;
        end else begin
            q <= d;
        end
    end

    assign sclk_o = q.sclk;
    assign cs_n_o = q.cs_n;
    assign mosi_o = q.active & q.shreg[FRAME_BITS-1];

    assert_sclk_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cs_n_o |-> !sclk_o);

    assert_mosi_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

endmodule

// File: rtl/adc_cfg_rom.sv
module adc_cfg_rom
    import adc_cfg_pkg::*;
#(
    parameter int          JITTER_EN    = 1,
    parameter int          DRIVE_WRITES = 0,
    parameter logic [15:0] LVDS_MODE    = 16'h0001,
    parameter int          STEP_W       = 5
) (
    input  logic [STEP_W-1:0] idx_i,
    output step_t             entry_o
);
    localparam int JIT      = (JITTER_EN != 0) ? 1 : 0;
    localparam int IDX_JIT  = 9;
    localparam int IDX_DRV  = IDX_JIT + JIT;
    localparam int IDX_PDHI = IDX_DRV + DRIVE_WRITES;
    localparam int IDX_PDLO = IDX_PDHI + 1;

    logic [STEP_W-1:0] drv_off;
    logic [15:0]       drv_val;
    logic              jit_hit;

    assign drv_off = idx_i - STEP_W'(IDX_DRV);
    assign drv_val = 16'h0777 - 16'h0111 * 16'(drv_off);

    generate
        if (JIT != 0) begin : g_jit
            assign jit_hit = (idx_i == STEP_W'(IDX_JIT));
        end else begin : g_nojit
            assign jit_hit = 1'b0;
        end
    endgenerate

    always_comb begin
        entry_o      = pin_step(1'b1, 1'b0);
        entry_o.kind = STEP_WAIT;
        if      (idx_i == STEP_W'(0)) entry_o = pin_step(1'b0, 1'b0);
        else if (idx_i == STEP_W'(1)) entry_o = pin_step(1'b1, 1'b0);
        else if (idx_i == STEP_W'(2)) entry_o = pin_step(1'b1, 1'b1);
        else if (idx_i == STEP_W'(3)) entry_o = pin_step(1'b1, 1'b0);
        else if (idx_i == STEP_W'(4)) entry_o = spi_step(8'h31, 16'h0001);
        else if (idx_i == STEP_W'(5)) entry_o = spi_step(8'h3A, 16'h0202);
        else if (idx_i == STEP_W'(6)) entry_o = spi_step(8'h3B, 16'h0202);
        else if (idx_i == STEP_W'(7)) entry_o = spi_step(8'h53, LVDS_MODE);
        else if (idx_i == STEP_W'(8)) entry_o = spi_step(8'h56, 16'h0008);
        else if (jit_hit)             entry_o = spi_step(8'h30, 16'h00FF);
        else if (idx_i >= STEP_W'(IDX_DRV) && idx_i < STEP_W'(IDX_PDHI))
                                      entry_o = spi_step(8'h11, drv_val);
        else if (idx_i == STEP_W'(IDX_PDHI)) entry_o = pin_step(1'b1, 1'b1);
        else if (idx_i == STEP_W'(IDX_PDLO)) entry_o = pin_step(1'b1, 1'b0);
    end

endmodule

// File: rtl/adc_cfg_seq.sv
module adc_cfg_seq
    import adc_cfg_pkg::*;
#(
    parameter int          TICK_CYCLES    = 1024,
    parameter int          CLK_DIV        = 10,
    parameter int          STARTUP_CYCLES = 2000,
    parameter int          JITTER_EN      = 1,
    parameter int          DRIVE_WRITES   = 0,
    parameter logic [15:0] LVDS_MODE      = 16'h0001
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic busy_o,
    output logic done_o,
    output logic adc_rst_n_o,
    output logic adc_pd_o,
    output logic spi_sclk_o,
    output logic spi_mosi_o,
    output logic spi_cs_n_o
);
    localparam int JIT        = (JITTER_EN != 0) ? 1 : 0;
    localparam int N_WRITES   = 5 + JIT + DRIVE_WRITES;
    localparam int IDX_WAIT   = 4 + N_WRITES + 2;
    localparam int WAIT_TICKS = (STARTUP_CYCLES + TICK_CYCLES - 1) / TICK_CYCLES;
    localparam int STEP_W     = $clog2(IDX_WAIT + 2);
    localparam int WAIT_W     = (WAIT_TICKS > 1) ? $clog2(WAIT_TICKS) : 1;
    localparam int SUP_W      = $clog2(STARTUP_CYCLES + 1);
    localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_TICKS - 1);

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              entry;
        logic [STEP_W-1:0] step;
        logic [WAIT_W-1:0] wait_cnt;
        logic              adc_rst_n;
        logic              adc_pd;
    } seq_state_t;

    seq_state_t d, q;
    step_t      rec;
    logic       tick_end;
    logic       spi_go;
    logic [SUP_W-1:0] since_pd_d, since_pd_q;

    adc_cfg_rom #(
        .JITTER_EN   (JITTER_EN),
        .DRIVE_WRITES(DRIVE_WRITES),
        .LVDS_MODE   (LVDS_MODE),
        .STEP_W      (STEP_W)
    ) u_rom (
        .idx_i  (q.step),
        .entry_o(rec)
    );

    adc_cfg_tick #(
        .TICK_CYCLES(TICK_CYCLES)
    ) u_tick (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .run_i     (q.busy),
        .tick_end_o(tick_end)
    );

    assign spi_go = q.busy && q.entry && (rec.kind == STEP_SPI);

    adc_cfg_spi #(
        .CLK_DIV(CLK_DIV)
    ) u_spi (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .go_i   (spi_go),
        .frame_i({rec.addr, rec.data}),
        .sclk_o (spi_sclk_o),
        .mosi_o (spi_mosi_o),
        .cs_n_o (spi_cs_n_o)
    );

    always_comb begin
        d       = q;
        d.done  = 1'b0;
        d.entry = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy     = 1'b1;
                d.step     = '0;
                d.entry    = 1'b1;
                d.wait_cnt = '0;
            end
        end else begin
            if (rec.kind == STEP_PIN) begin
                d.adc_rst_n = rec.rst_n;
                d.adc_pd    = rec.pd;
            end
            if (tick_end) begin
                if (rec.kind == STEP_WAIT) begin
                    if (q.wait_cnt == WAIT_LAST) begin
                        d.busy = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.wait_cnt = q.wait_cnt + 1'b1;
                    end
                end else begin
                    d.step  = q.step + 1'b1;
                    d.entry = 1'b1;
                end
            end
        end
    end

    // Cycles since power-down was last released, saturating at the startup time.
    always_comb begin
        since_pd_d = since_pd_q;
        if (q.adc_pd) begin
            since_pd_d = '0;
        end else if (since_pd_q != SUP_W'(STARTUP_CYCLES)) begin
            since_pd_d = since_pd_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q.busy      <= 1'b0;
            q.done      <= 1'b0;
            q.entry     <= 1'b0;
            q.step      <= '0;
            q.wait_cnt  <= '0;
            q.adc_rst_n <= 1'b1;
            q.adc_pd    <= 1'b0;
            since_pd_q  <= '0;
        end else begin
            q          <= d;
            since_pd_q <= since_pd_d;
        end
    end

    assign busy_o      = q.busy;
    assign done_o      = q.done;
    assign adc_rst_n_o = q.adc_rst_n;
    assign adc_pd_o    = q.adc_pd;

    assert_done_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_done_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !busy_o);

    assert_start_ignored_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && start_i && !tick_end) |=> (busy_o && $stable(q.step)));

    assert_frame_pins_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !spi_cs_n_o |-> (adc_rst_n_o && !adc_pd_o));

    assert_startup_wait_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> (since_pd_q == SUP_W'(STARTUP_CYCLES)));

endmodule

// File: tb/adc_cfg_spi_mon.sv
module adc_cfg_spi_mon #(
    parameter int HALF = 5,
    parameter int MAXF = 16
) (
    input logic clk,
    input logic sclk,
    input logic mosi,
    input logic cs_n,
    input logic pin_rst_n,
    input logic pin_pd,
    input int   cyc
);
    logic [23:0] frames      [MAXF];
    int          nbits       [MAXF];
    int          cs_fall_cyc [MAXF];
    int          cs_rise_cyc [MAXF];
    int          nf         = 0;
    int          period_err = 0;
    int          edge_err   = 0;
    int          pin_err    = 0;

    logic        prev_cs    = 1'b1;
    logic        prev_sclk  = 1'b0;
    logic        prev_mosi  = 1'b0;
    logic [23:0] shreg      = '0;
    int          bits       = 0;
    int          run        = 0;

    always @(negedge clk) begin
        if (!cs_n && prev_cs) begin
            if (nf < MAXF) cs_fall_cyc[nf] = cyc;
            shreg = '0;
            bits  = 0;
            run   = 1;
            if (!pin_rst_n || pin_pd) pin_err++;
        end else if (!cs_n) begin
            if (sclk != prev_sclk) begin
                if (run != HALF) period_err++;
                run = 1;
                if (sclk) begin
                    shreg = {shreg[22:0], mosi};
                    bits++;
                end
            end else begin
                run++;
            end
            if (mosi != prev_mosi && !(prev_sclk && !sclk)) edge_err++;
        end
        if (cs_n && !prev_cs) begin
            if (nf < MAXF) begin
                frames[nf]      = shreg;
                nbits[nf]       = bits;
                cs_rise_cyc[nf] = cyc;
            end
            nf++;
        end
        prev_cs   = cs_n;
        prev_sclk = sclk;
        prev_mosi = mosi;
    end
endmodule

// File: tb/adc_cfg_seq_bench.sv
module adc_cfg_seq_bench;
    localparam int TICK = 1024;
    localparam int NF   = 10;
    localparam int NF_M = 5;

    // Vector table: {step index, expected 24-bit frame}
    localparam logic [31:0] VEC [NF] = '{
        {8'd4,  24'h310001}, {8'd5,  24'h3A0202}, {8'd6,  24'h3B0202},
        {8'd7,  24'h530001}, {8'd8,  24'h560008}, {8'd9,  24'h3000FF},
        {8'd10, 24'h110777}, {8'd11, 24'h110666}, {8'd12, 24'h110555},
        {8'd13, 24'h110444}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    int   cyc = 0;
    int   n_chk = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    logic busy, done, a_rst_n, a_pd, sclk, mosi, cs_n;
    logic busy_m, done_m, a_rst_n_m, a_pd_m, sclk_m, mosi_m, cs_n_m;

    adc_cfg_seq #(.JITTER_EN(1), .DRIVE_WRITES(4)) u_adc_cfg_seq (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy), .done_o(done),
        .adc_rst_n_o(a_rst_n), .adc_pd_o(a_pd),
        .spi_sclk_o(sclk), .spi_mosi_o(mosi), .spi_cs_n_o(cs_n));

    adc_cfg_seq #(.JITTER_EN(0), .DRIVE_WRITES(0)) u_adc_cfg_seq_min (
        .clk_i(clk), .rst_ni(rst_n), .start_i(start), .busy_o(busy_m), .done_o(done_m),
        .adc_rst_n_o(a_rst_n_m), .adc_pd_o(a_pd_m),
        .spi_sclk_o(sclk_m), .spi_mosi_o(mosi_m), .spi_cs_n_o(cs_n_m));

    adc_cfg_spi_mon #(.HALF(5)) u_mon (
        .clk(clk), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
        .pin_rst_n(a_rst_n), .pin_pd(a_pd), .cyc(cyc));

    adc_cfg_spi_mon #(.HALF(5)) u_mon_m (
        .clk(clk), .sclk(sclk_m), .mosi(mosi_m), .cs_n(cs_n_m),
        .pin_rst_n(a_rst_n_m), .pin_pd(a_pd_m), .cyc(cyc));

    // Transition stamps, sampled on the falling clock edge.
    int busy_rise = -1, busy_fall = -1, busy_rises = 0, done_cyc = -1, done_cnt = 0;
    int rst_fall = -1, rst_rise = -1, busy_fall_m = -1, done_cnt_m = 0;
    int pd_rise [2] = '{-1, -1};
    int pd_fall [2] = '{-1, -1};
    int npr = 0, npf = 0;
    logic p_busy = 1'b0, p_rst = 1'b1, p_pd = 1'b0, p_busy_m = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (busy && !p_busy) begin busy_rise = cyc; busy_rises++; end
            if (!busy && p_busy) busy_fall = cyc;
            if (!busy_m && p_busy_m) busy_fall_m = cyc;
            if (done) begin done_cnt++; if (done_cyc < 0) done_cyc = cyc; end
            if (done_m) done_cnt_m++;
            if (!a_rst_n && p_rst) rst_fall = cyc;
            if (a_rst_n && !p_rst) rst_rise = cyc;
            if (a_pd && !p_pd) begin if (npr < 2) pd_rise[npr] = cyc; npr++; end
            if (!a_pd && p_pd) begin if (npf < 2) pd_fall[npf] = cyc; npf++; end
        end
        p_busy = busy; p_busy_m = busy_m; p_rst = a_rst_n; p_pd = a_pd;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int t0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(a_rst_n == 1'b1, "R1", "adc reset pin", a_rst_n, 1);
        check(a_pd == 1'b0,    "R1", "power-down pin", a_pd, 0);
        check(cs_n == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R1", "spi idle {cs,sclk,mosi}",
              {cs_n, sclk, mosi}, 3'b100);
        check(busy == 1'b0 && done == 1'b0, "R1", "busy/done", {busy, done}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        start = 1'b1;
        t0 = cyc + 1;
        @(negedge clk);
        start = 1'b0;
        // R12: extra start request in the middle of the write steps
        repeat (6 * TICK) @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (done_cyc < 0) @(negedge clk);
        repeat (50) @(negedge clk);

        // Vector walk: frames, their step timing and their length (R3, R5, R7, R8, R9)
        for (int i = 0; i < NF; i++) begin
            int    stp;
            string tag;
            stp = int'(VEC[i][31:24]);
            tag = (i < 5) ? "R7" : ((i == 5) ? "R8" : "R9");
            check(u_mon.frames[i] == VEC[i][23:0], tag, $sformatf("frame %0d", i),
                  u_mon.frames[i], VEC[i][23:0]);
            check(u_mon.cs_fall_cyc[i] == t0 + 1 + stp * TICK, "R3",
                  $sformatf("frame %0d start cycle", i), u_mon.cs_fall_cyc[i], t0 + 1 + stp * TICK);
            check(u_mon.nbits[i] == 24, "R5", $sformatf("frame %0d bit count", i),
                  u_mon.nbits[i], 24);
        end

        // R2: busy length and done pulse
        check(busy_rise == t0, "R2", "busy rise cycle", busy_rise, t0);
        check(busy_fall == t0 + 18 * TICK, "R2", "busy fall cycle", busy_fall, t0 + 18 * TICK);
        check(done_cyc == t0 + 18 * TICK, "R2", "done cycle", done_cyc, t0 + 18 * TICK);
        check(done_cnt == 1, "R2", "done width", done_cnt, 1);
        // R4: opening pin steps
        check(rst_fall == t0 + 1, "R4", "reset assert cycle", rst_fall, t0 + 1);
        check(rst_rise == t0 + 1 + TICK, "R4", "reset release cycle", rst_rise, t0 + 1 + TICK);
        check(pd_rise[0] == t0 + 1 + 2 * TICK, "R4", "pd assert cycle", pd_rise[0], t0 + 1 + 2 * TICK);
        check(pd_fall[0] == t0 + 1 + 3 * TICK, "R4", "pd release cycle", pd_fall[0], t0 + 1 + 3 * TICK);
        // R10: final power-down cycle after the last frame
        check(pd_rise[1] == t0 + 1 + 14 * TICK, "R10", "second pd assert", pd_rise[1], t0 + 1 + 14 * TICK);
        check(pd_fall[1] == t0 + 1 + 15 * TICK, "R10", "second pd release", pd_fall[1], t0 + 1 + 15 * TICK);
        check(u_mon.cs_rise_cyc[NF-1] < pd_rise[1], "R10", "last frame end before pd",
              u_mon.cs_rise_cyc[NF-1], pd_rise[1]);
        // R12: the stray start changed nothing
        check(u_mon.nf == NF, "R12", "frame count", u_mon.nf, NF);
        check(busy_rises == 1, "R12", "busy rise count", busy_rises, 1);
        // R11: startup wait
        check(done_cyc - pd_fall[1] >= 2000, "R11", "cycles pd release to done",
              done_cyc - pd_fall[1], 2000);
        // R5, R6, R13: monitor error counters
        check(u_mon.period_err == 0, "R6", "sclk phase width errors", u_mon.period_err, 0);
        check(u_mon.edge_err == 0, "R5", "mosi change off falling edge", u_mon.edge_err, 0);
        check(u_mon.pin_err == 0, "R13", "frame with reset/pd active", u_mon.pin_err, 0);
        // R8, R9: variant without jitter and drive writes
        check(u_mon_m.nf == NF_M, "R8", "min variant frame count", u_mon_m.nf, NF_M);
        for (int i = 0; i < NF_M; i++) begin
            check(u_mon_m.frames[i] == VEC[i][23:0], "R9", $sformatf("min frame %0d", i),
                  u_mon_m.frames[i], VEC[i][23:0]);
        end
        check(busy_fall_m == t0 + 13 * TICK, "R2", "min variant busy fall",
              busy_fall_m, t0 + 13 * TICK);
        check(done_cnt_m == 1, "R2", "min variant done count", done_cnt_m, 1);
        check(u_mon_m.period_err == 0 && u_mon_m.edge_err == 0, "R6", "min variant spi errors",
              u_mon_m.period_err + u_mon_m.edge_err, 0);

        finished = 1'b1;
        summary();
        $finish;
    end
endmodule